// File: doc/BRIEF.md
# Quasi-Bidirectional Port

This block is an eight-bit general-purpose port with no direction register. Each pin owns one output latch. A latch bit of 0 switches on a strong pull-down, so the pin goes low. A latch bit of 1 releases the pull-down, so the pin can be read as an input. In that state the pin sits weakly high, or floats if the open-drain variant is chosen. The host loads all latch bits at once with a write strobe.

Reads come through two separate strobes. One strobe returns the latch contents. The other returns the pin levels as seen through a two-flop synchronizer. After reset every latch bit holds 1, so every pin is released and weakly high.

The pad itself lives outside the block. The block drives two enables per pin, a pull-down and a weak pull-up. The resolved pad level comes back on a separate input, and the board or testbench resolves it. When the latch holds 1 and an external driver pulls the pin low, the pin reads 0, which gives a wired-AND.

Top module: `qb_gpio_port`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every latch bit becomes 1 (so `pad_pull_dn` is all zero) and `rd_data` becomes 0.
- R2: The latch loads `wr_data` at a rising edge only when `wr_en` is high. With `wr_en` low, the latch keeps its value.
- R3: Bit i of `pad_pull_dn` is 1 exactly when latch bit i holds 0.
- R4: With `OPEN_DRAIN`=0, bit i of `pad_pull_up` is 1 exactly when latch bit i holds 1.
- R5: With `OPEN_DRAIN`=1, `pad_pull_up` is always 0, so a pin whose latch holds 1 is left floating.
- R6: A rising edge with `rd_latch_en` high loads `rd_data` with the latch value from before that edge. When `wr_en` is high in the same cycle, the old value is returned. The pin level is not used.
- R7: A rising edge with `rd_pin_en` high and `rd_latch_en` low loads `rd_data` with the `pad_in` value that was sampled two rising edges earlier (a two-flop synchronizer).
- R8: When both read strobes are high, the latch read wins. A rising edge with neither strobe high loads `rd_data` with 0.
- R9: A pin whose latch holds 1 reads back the external level, and an external low reads as 0. A pin whose latch holds 0 reads 0 whatever the external level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Latch write strobe |
| wr_data | input | 8 | Data loaded into the latch |
| rd_latch_en | input | 1 | Read strobe for the latch contents |
| rd_pin_en | input | 1 | Read strobe for the synchronized pin levels |
| rd_data | output | 8 | Registered read result |
| pad_in | input | 8 | Resolved pad levels |
| pad_pull_dn | output | 8 | Strong pull-down enable per pin |
| pad_pull_up | output | 8 | Weak pull-up enable per pin |

## Verification
The bound checker evaluates these properties on every clock edge:
- the reset state;
- that the latch is loaded only by a write;
- the latch read-back against the pull-down enables, including the case where a write and a latch read share a cycle;
- the three-edge delay of the pin read path;
- read priority and the zero idle result;
- the pull-up being absent in the open-drain variant.

Only the bench scenarios show the effect of the board on the pin. In those scenarios a tri-state resolution of external drivers is applied, an external low is seen through a released pin as a wired-AND, and a pin held low by its own latch ignores an external high.

// File: rtl/qb_gpio_pkg.sv
// Package: shared types and helpers for the quasi-bidirectional port.
// Assumes: read source is chosen by two independent strobes.
package qb_gpio_pkg;

    typedef enum logic [1:0] {
        RD_SRC_NONE  = 2'd0,
        RD_SRC_LATCH = 2'd1,
        RD_SRC_PIN   = 2'd2
    } rd_src_e;

    // Latch read has priority over pin read.
    function automatic rd_src_e pick_rd_src(input logic latch_req, input logic pin_req);
        if (latch_req)    return RD_SRC_LATCH;
        else if (pin_req) return RD_SRC_PIN;
        else              return RD_SRC_NONE;
    endfunction

endpackage

// File: rtl/qb_port_latch.sv
// Module: per-pin output latch and pad drive enables.
// Assumes: synchronous active-low reset sets every latch bit to 1 (pins
// released). OPEN_DRAIN selects the variant without an internal pull-up.
module qb_port_latch #(
    parameter int WIDTH      = 8,
    parameter bit OPEN_DRAIN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] pull_dn,
    output logic [WIDTH-1:0] pull_up
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Store one pin's output bit; loads only on a write strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)     latch_q[i] <= 1'b1;
            else if (wr_en) latch_q[i] <= wr_data[i];
        end

        // Pull-down is on whenever the latch holds 0.
        assign pull_dn[i] = ~latch_q[i];

        if (OPEN_DRAIN) begin : g_od
            // Open-drain variant: no internal pull-up, pin floats when released.
            assign pull_up[i] = 1'b0;
        end else begin : g_std
            // Standard variant: weak pull-up while released.
            assign pull_up[i] = latch_q[i];
        end
    end

endmodule

// File: rtl/qb_pin_sync.sv
// Module: multi-flop synchronizer for the pad levels.
// Assumes: STAGES >= 2; flops carry no reset since they only track the pad.
module qb_pin_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift the pad sample through the flop chain.
    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[LAST];

endmodule

// File: rtl/qb_read_mux.sv
// Module: read source selection and registered read data.
// Assumes: latch read has priority; idle cycles return zero.
module qb_read_mux
    import qb_gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_latch_en,
    input  logic             rd_pin_en,
    input  logic [WIDTH-1:0] latch_val,
    input  logic [WIDTH-1:0] pin_val,
    output logic [WIDTH-1:0] rd_data
);

    rd_src_e          src;
    logic [WIDTH-1:0] rd_next;

    // Choose the read source and the next read value.
    always_comb begin
        src = pick_rd_src(rd_latch_en, rd_pin_en);
        unique case (src)
            RD_SRC_LATCH: rd_next = latch_val;
            RD_SRC_PIN:   rd_next = pin_val;
            default:      rd_next = '0;
        endcase
    end

    // Register the read result.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_next;
    end

endmodule

// File: rtl/qb_gpio_port.sv
// Module: quasi-bidirectional port top.
// Assumes: pad resolution is external; pad_in carries the resolved level.
module qb_gpio_port #(
    parameter int WIDTH       = 8,
    parameter bit OPEN_DRAIN  = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_latch_en,
    input  logic             rd_pin_en,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_pull_dn,
    output logic [WIDTH-1:0] pad_pull_up
);

    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] pin_sync;

    qb_port_latch #(.WIDTH(WIDTH), .OPEN_DRAIN(OPEN_DRAIN)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .latch_q (latch_q),
        .pull_dn (pad_pull_dn),
        .pull_up (pad_pull_up)
    );

    qb_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  (pad_in),
        .dout (pin_sync)
    );

    qb_read_mux #(.WIDTH(WIDTH)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_latch_en (rd_latch_en),
        .rd_pin_en   (rd_pin_en),
        .latch_val   (latch_q),
        .pin_val     (pin_sync),
        .rd_data     (rd_data)
    );

endmodule

// File: rtl/qb_gpio_port_chk.sv
// Module: port-level property checker, bound to every qb_gpio_port.
// Assumes: the pin-path delay property applies only with two sync stages.
module qb_gpio_port_chk #(
    parameter int WIDTH       = 8,
    parameter bit OPEN_DRAIN  = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [WIDTH-1:0] wr_data,
    input logic             rd_latch_en,
    input logic             rd_pin_en,
    input logic [WIDTH-1:0] rd_data,
    input logic [WIDTH-1:0] pad_in,
    input logic [WIDTH-1:0] pad_pull_dn,
    input logic [WIDTH-1:0] pad_pull_up
);

    logic [1:0] since_rst;

    // Count rising edges since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (pad_pull_dn == '0 && rd_data == '0));

    assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> pad_pull_dn == ~$past(wr_data));

    assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !wr_en) |=> $stable(pad_pull_dn));

    assert_latch_read_old_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_latch_en |=> rd_data == ~$past(pad_pull_dn));

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_latch_en && !rd_pin_en) |=> rd_data == '0);

    if (SYNC_STAGES == 2) begin : g_pin
        assert_pin_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == 2'd3 && rd_pin_en && !rd_latch_en) |=> rd_data == $past(pad_in, 3));
    end

    if (OPEN_DRAIN) begin : g_od
        assert_no_pullup_R5: assert property (@(posedge clk) disable iff (!rst_n)
            pad_pull_up == '0);
    end

endmodule

bind qb_gpio_port qb_gpio_port_chk #(
    .WIDTH(WIDTH), .OPEN_DRAIN(OPEN_DRAIN), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/test_qb_gpio_port.sv
module test_qb_gpio_port;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_latch_en = 1'b0;
    logic         rd_pin_en = 1'b0;
    logic [W-1:0] ext_en = '0;   // external driver active per pin
    logic [W-1:0] ext_val = '0;  // external driver level per pin

    logic [W-1:0] rd_s, dn_s, up_s, pad_s;
    logic [W-1:0] rd_o, dn_o, up_o, pad_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    // Tri-state resolution: pull-down or external low wins, then external
    // high, then internal pull-up or board pull-up.
    function automatic logic [W-1:0] resolve(input logic [W-1:0] dn, input logic [W-1:0] up,
                                             input logic board_pu);
        logic [W-1:0] r;
        for (int b = 0; b < W; b++) begin
            if (dn[b] || (ext_en[b] && !ext_val[b])) r[b] = 1'b0;
            else if (ext_en[b])                      r[b] = 1'b1;
            else                                     r[b] = up[b] | board_pu;
        end
        return r;
    endfunction

    assign pad_s = resolve(dn_s, up_s, 1'b0);
    assign pad_o = resolve(dn_o, up_o, 1'b1);  // open-drain board has a resistor

    qb_gpio_port #(.WIDTH(W), .OPEN_DRAIN(1'b0)) i_qb_gpio_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_latch_en(rd_latch_en), .rd_pin_en(rd_pin_en), .rd_data(rd_s),
        .pad_in(pad_s), .pad_pull_dn(dn_s), .pad_pull_up(up_s));

    qb_gpio_port #(.WIDTH(W), .OPEN_DRAIN(1'b1)) i_qb_gpio_port_od (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_latch_en(rd_latch_en), .rd_pin_en(rd_pin_en), .rd_data(rd_o),
        .pad_in(pad_o), .pad_pull_dn(dn_o), .pad_pull_up(up_o));

    // Behavioural reference model (shared by both variants).
    logic [W-1:0] m_latch = '1;
    logic [W-1:0] m_rd = '0;
    logic [W-1:0] pad_hist[$];
    string        rd_tag = "R1";

    always @(posedge clk) begin
        logic [W-1:0] lvl;
        logic [W-1:0] sampled;
        cyc++;
        lvl = '0;
        for (int b = 0; b < W; b++)
            lvl[b] = !m_latch[b] ? 1'b0 : (ext_en[b] ? ext_val[b] : 1'b1);
        sampled = (pad_hist.size() >= 2) ? pad_hist[1] : '0;
        if (!rst_n) begin
            m_rd = '0; rd_tag = "R1";
        end else if (rd_latch_en) begin
            m_rd = m_latch; rd_tag = wr_en ? "R6/R8 old" : (rd_pin_en ? "R8" : "R6");
        end else if (rd_pin_en) begin
            m_rd = sampled; rd_tag = "R7/R9";
        end else begin
            m_rd = '0; rd_tag = "R8";
        end
        pad_hist.push_front(lvl);
        if (pad_hist.size() > 4) void'(pad_hist.pop_back());
        if (!rst_n)     m_latch = '1;
        else if (wr_en) m_latch = wr_data;
    end

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    // Compare every output of both instances against the model on every clock.
    always @(negedge clk) begin
        if (cyc >= 2) begin
            check({"std rd ", rd_tag}, rd_s, m_rd);
            check({"od rd ", rd_tag}, rd_o, m_rd);
            check("R3 std pull_dn", dn_s, ~m_latch);
            check("R3 od pull_dn", dn_o, ~m_latch);
            check("R4 std pull_up", up_s, m_latch);
            check("R5 od pull_up", up_o, '0);
        end
    end

    task automatic step(input logic we, input logic [W-1:0] d, input logic rl, input logic rp);
        @(negedge clk); #2;
        wr_en = we; wr_data = d; rd_latch_en = rl; rd_pin_en = rp;
    endtask

    // Directed stimulus with explicit expectations at the ports.
    initial begin
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset pull_dn", dn_s, '0);
        check("R1 reset pull_up", up_s, 8'hFF);
        check("R1 reset rd_data", rd_s, '0);
        step(1'b0, '0, 1'b1, 1'b0);
        step(1'b0, '0, 1'b0, 1'b0);
        check("R1 reset latch read", rd_s, 8'hFF);
        // R2: write then confirm hold without write.
        step(1'b1, 8'hA5, 1'b0, 1'b0);
        step(1'b0, 8'h0F, 1'b0, 1'b0);
        step(1'b0, 8'h0F, 1'b1, 1'b0);
        step(1'b0, '0, 1'b0, 1'b0);
        check("R2 write A5 held", rd_s, 8'hA5);
        // R6: write and latch read in one cycle return the old value.
        step(1'b1, 8'h3C, 1'b1, 1'b0);
        step(1'b0, '0, 1'b0, 1'b0);
        check("R6 same-cycle read old", rd_s, 8'hA5);
        // R8: both strobes, latch wins over pins.
        ext_en = 8'hFF; ext_val = 8'h00;
        step(1'b0, '0, 1'b1, 1'b1);
        step(1'b0, '0, 1'b0, 1'b0);
        check("R8 latch priority", rd_s, 8'h3C);
        // R9: release all pins, external low gives wired-AND.
        step(1'b1, 8'hFF, 1'b0, 1'b0);
        ext_en = 8'h0F; ext_val = 8'h00;
        repeat (3) step(1'b0, '0, 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b1);
        step(1'b0, '0, 1'b0, 1'b0);
        check("R9 wired-AND low", rd_s, 8'hF0);
        // R9: latch 0 pins read 0 despite external high.
        ext_en = 8'hFF; ext_val = 8'hFF;
        step(1'b1, 8'h55, 1'b0, 1'b0);
        repeat (3) step(1'b0, '0, 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b1);
        step(1'b0, '0, 1'b0, 1'b0);
        check("R9 driven-low pins", rd_s, 8'h55);
        // Mixed stimulus, checked against the model every cycle.
        for (int i = 0; i < 400; i++) begin
            ext_en  = 8'($urandom);
            ext_val = 8'($urandom);
            step(($urandom % 3) == 0, 8'($urandom), ($urandom % 3) == 0, ($urandom % 2) == 0);
        end
        // R1: reset mid-run restores released pins.
        step(1'b1, 8'h00, 1'b0, 1'b0);
        @(negedge clk); #2 rst_n = 1'b0;
        step(1'b0, '0, 1'b0, 1'b0);
        @(negedge clk); #2 rst_n = 1'b1;
        @(negedge clk);
        check("R1 re-reset pull_dn", dn_s, '0);
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule